// File: doc/BRIEF.md
# Byte-wide SPI master with memory-mapped registers

This block is a programmed-I/O SPI master. A CPU drives it through two 32-bit word registers and exchanges one byte per transfer. The control word at offset 0x0 carries several fields:

- a clock divider in its top bits;
- one chip-select bit per slave, on the even bit positions;
- a loopback enable;
- a start bit that reads back as busy.

The data word at offset 0x4 holds the byte to send before a transfer and the byte received after it.

The SPI clock is produced in hardware from the system clock. Each half-period of the SPI clock lasts D+1 system cycles, where D is the divider field. Transfers follow SPI mode 3 and send the most significant bit first.

The chip-select lines are register bits routed straight to the pins. Software asserts a select by writing its bit low with the start bit clear. It then loads the data word and writes the control word again with the start bit set. It polls busy, and reads the received byte once busy has cleared.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control word reads 0x0000_0015 (divider 0, loopback off, busy 0, all selects high). The data word reads 0. `spi_sclk` is 1, `spi_mosi` is 0 and `spi_cs_n` is 3'b111.
- R2: The control word sits at byte offset 0x0 and the data word at 0x4. A read of any other offset returns 0.
- R3: `spi_cs_n[n]` follows control bit 2*n (bits 0, 2 and 4), where 1 means inactive. A control write with bit 1 clear updates the selects on the next cycle, leaves busy at 0 and produces no SPI clock edges.
- R4: A control write with bit 1 set while idle makes busy (control bit 1) read 1 from the next cycle. Busy stays 1 for exactly 16*(D+1) system cycles.
- R5: `spi_sclk` idles high. During a transfer it makes 8 low pulses. Each low pulse lasts D+1 system cycles, and the first falling edge comes D+1 cycles after the start write.
- R6: `spi_mosi` changes only when `spi_sclk` falls and is stable while `spi_sclk` is high. It carries the data byte MSB first.
- R7: `spi_miso` is sampled as `spi_sclk` rises, MSB first. After busy clears, the data word reads the received byte in bits 7:0 and 0 in bits 31:8.
- R8: With control bit 3 set, the receiver takes the MOSI bit internally and ignores `spi_miso`, so the received byte equals the byte sent.
- R9: While busy, writes to either register are ignored. The selects, divider and loopback keep their values, and the byte being shifted is not disturbed.
- R10: `spi_mosi` is 0 whenever no transfer is in progress.
- R11: Control bits 31:27 hold the divider D. They read back as written, and the other unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| spi_sclk | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
The assertions take two things for granted:

- reset is applied before the first write;
- each write lasts a single cycle at a word-aligned offset.

The properties on SCLK and MOSI do not depend on `spi_miso`. The receive checks do assume that `spi_miso` settles away from the cycle in which SCLK rises. The bench therefore acts as a slave that shifts its next bit half a system cycle after it sees SCLK go high, well before the next rising edge. It only issues writes during a transfer to exercise the busy-time write rule.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int NCS   = 3,
  parameter int DIV_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [3:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            spi_sclk,
  output logic            spi_mosi,
  input  logic            spi_miso,
  output logic [NCS-1:0]  spi_cs_n
);
  localparam int DIV_LSB = 32 - DIV_W;
  localparam logic [3:0] LAST_EDGE = 4'd15;

  logic [DIV_W-1:0] div_q, cnt_q;
  logic             loop_q, busy_q, sclk_q, mosi_q;
  logic [NCS-1:0]   cs_q, cs_wr;
  logic [7:0]       sh_q;
  logic [3:0]       edge_q;
  logic [31:0]      ctrl_rd;

  wire sel_ctrl = (bus_addr == 4'h0);
  wire sel_data = (bus_addr == 4'h4);
  wire wr_ctrl  = bus_wr && sel_ctrl && !busy_q;
  wire wr_data  = bus_wr && sel_data && !busy_q;
  wire tick     = busy_q && (cnt_q == div_q);
  wire rx_bit   = loop_q ? mosi_q : spi_miso;

  for (genvar n = 0; n < NCS; n++) begin : g_cs
    assign cs_wr[n] = bus_wdata[2*n];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[31:DIV_LSB] = div_q;
    ctrl_rd[3] = loop_q;
    ctrl_rd[1] = busy_q;
    for (int n = 0; n < NCS; n++) ctrl_rd[2*n] = cs_q[n];
  end

  assign bus_rdata = sel_ctrl ? ctrl_rd : sel_data ? {24'h0, sh_q} : 32'h0;
  assign spi_sclk  = sclk_q;
  assign spi_mosi  = mosi_q;
  assign spi_cs_n  = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      loop_q <= 1'b0;
      cs_q   <= '1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      edge_q <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        div_q  <= bus_wdata[31:DIV_LSB];
        loop_q <= bus_wdata[3];
        cs_q   <= cs_wr;
        if (bus_wdata[1]) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          edge_q <= '0;
        end
      end
      if (wr_data) sh_q <= bus_wdata[7:0];
      if (busy_q) begin
        if (tick) begin
          cnt_q  <= '0;
          edge_q <= edge_q + 4'd1;
          if (!edge_q[0]) begin
            sclk_q <= 1'b0;
            mosi_q <= sh_q[7];
          end else begin
            sclk_q <= 1'b1;
            sh_q   <= {sh_q[6:0], rx_bit};
            if (edge_q == LAST_EDGE) begin
              busy_q <= 1'b0;
              mosi_q <= 1'b0;
            end
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctrl && bus_wdata[1] && !busy_q) |=> busy_q);

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> spi_sclk);

  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  p_cs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(spi_cs_n));

  p_mosi_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !spi_mosi);
endmodule

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi;
  logic [2:0]  spi_cs_n;
  logic [7:0]  slv = 8'h00;
  wire         spi_miso = slv[7];

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct { logic [7:0] tx; int half; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // monitor: collects MOSI on SCLK falls, low-pulse widths, shifts slave on rises
  logic       prev_sclk = 1'b1;
  logic [7:0] mbits = 8'h00;
  int         nbits = 0;
  int         lowcnt = 0;
  int         cur_half = 1;
  bit         width_ok = 1'b1;
  int         bad_width = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_sclk && !spi_sclk) mbits = {mbits[6:0], spi_mosi};
      if (!spi_sclk) lowcnt++;
      if (!prev_sclk && spi_sclk) begin
        if (nbits == 0 && q.size() > 0) cur_half = q[0].half;
        if (lowcnt != cur_half) begin width_ok = 1'b0; bad_width = lowcnt; end
        lowcnt = 0;
        slv = {slv[6:0], 1'b0};
        nbits++;
        if (nbits == 8) begin
          item_t it;
          nbits = 0;
          if (q.size() == 0) begin
            check(1'b0, "R6 unexpected byte on MOSI", {24'h0, mbits}, 32'h0);
          end else begin
            it = q.pop_front();
            check(mbits == it.tx, "R6 MOSI byte MSB first", {24'h0, mbits}, {24'h0, it.tx});
            check(width_ok, "R5 SCLK low half-period", bad_width, it.half);
          end
          width_ok = 1'b1;
        end
      end
      prev_sclk = spi_sclk;
    end
  end

  task automatic start_xfer(input logic [7:0] tx, input logic [7:0] sv, input int div,
                            input bit lp, input logic [31:0] csb);
    item_t it;
    wr(4'h4, {24'h0, tx});
    slv = sv;
    it.tx = tx; it.half = div + 1;
    q.push_back(it);
    wr(4'h0, (32'(div) << 27) | csb | (32'(lp) << 3) | 32'h2);
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] r;
    n = 0;
    rd(4'h0, r);
    while (r[1] && n < 5000) begin
      n++;
      @(negedge clk);
      rd(4'h0, r);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rd(4'h0, r);
    check(r == 32'h15, "R1 control reset value", r, 32'h15);
    rd(4'h4, r);
    check(r == 32'h0, "R1 data reset value", r, 32'h0);
    check(spi_sclk === 1'b1, "R1 sclk idle high", spi_sclk, 1);
    check(spi_mosi === 1'b0, "R1 mosi low", spi_mosi, 0);
    check(spi_cs_n === 3'b111, "R1 selects inactive", spi_cs_n, 3'b111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    rd(4'h8, r);
    check(r == 32'h0, "R2 unmapped offset reads zero", r, 0);

    wr(4'h0, 32'h14);
    check(spi_cs_n === 3'b110, "R3 select 0 asserted", spi_cs_n, 3'b110);
    rd(4'h0, r);
    check(r == 32'h14, "R3 control readback, no busy", r, 32'h14);
    repeat (10) begin
      @(negedge clk);
      if (spi_sclk !== 1'b1) check(1'b0, "R3 no SCLK activity", spi_sclk, 1);
    end
    check(spi_sclk === 1'b1, "R3 sclk still idle", spi_sclk, 1);

    wr(4'h0, 32'h2800_0015);
    rd(4'h0, r);
    check(r == 32'h2800_0015, "R11 divider readback", r, 32'h2800_0015);
    check(spi_cs_n === 3'b111, "R3 selects released", spi_cs_n, 3'b111);

    start_xfer(8'hA5, 8'h3C, 0, 1'b0, 32'h14);
    rd(4'h0, r);
    check(r[1], "R4 busy after start", r, 32'h2);
    wait_idle(n);
    check(n == 16, "R4 busy length D=0", n, 16);
    rd(4'h4, r);
    check(r == 32'h3C, "R7 received byte D=0", r, 32'h3C);
    check(spi_mosi === 1'b0, "R10 mosi low when idle", spi_mosi, 0);

    start_xfer(8'h81, 8'hF0, 2, 1'b0, 32'h11);
    check(spi_cs_n === 3'b101, "R3 select 1 asserted during transfer", spi_cs_n, 3'b101);
    wait_idle(n);
    check(n == 48, "R4 busy length D=2", n, 48);
    rd(4'h4, r);
    check(r == 32'hF0, "R7 received byte D=2", r, 32'hF0);

    start_xfer(8'h5A, 8'hFF, 1, 1'b1, 32'h05);
    wait_idle(n);
    check(n == 32, "R4 busy length D=1", n, 32);
    rd(4'h4, r);
    check(r == 32'h5A, "R8 loopback ignores MISO", r, 32'h5A);
    rd(4'h0, r);
    check(r == 32'h0800_000D, "R8 loopback bit readback", r, 32'h0800_000D);

    start_xfer(8'h33, 8'hC6, 3, 1'b0, 32'h14);
    repeat (5) @(negedge clk);
    wr(4'h0, 32'h0000_000B);
    wr(4'h4, 32'h0000_00EE);
    check(spi_cs_n === 3'b110, "R9 selects unchanged by busy write", spi_cs_n, 3'b110);
    rd(4'h0, r);
    check(r == 32'h1800_0016, "R9 control unchanged by busy write", r, 32'h1800_0016);
    wait_idle(n);
    rd(4'h4, r);
    check(r == 32'hC6, "R9 shift byte undisturbed", r, 32'hC6);
    check(spi_mosi === 1'b0, "R10 mosi low after transfer", spi_mosi, 0);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R6 every byte observed on MOSI", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule